// File: doc/BRIEF.md
# I2C Byte-Command Controller

This block is an I2C bus controller that software steers one byte at a time through a small byte-addressed register window. A single 16-bit command word does each step. It can open a transfer with a START and the target address, shift out one write byte, clock in one read byte with or without an acknowledge, or close the transfer with a STOP. After every address or data byte the controller raises a completion event, asserts its interrupt line and parks the bus with SCL pulled low. It does nothing more until software writes the next command with the event-clear bit set.

SCL and SDA are open-drain: the block only pulls a line low or releases it, and it reads the resolved SDA level back. The bus rate comes from a divider register counted in ticks of an internal 2 MHz time base, so software loads 2,000,000 divided by the wanted rate. A START issued while the bus is parked produces a repeated START. If SDA reads low while the controller is sending a one, it reports a lost arbitration and lets go of both lines.

Top module: `i2c_byte_engine`

## Requirements
- R1: After reset both bus lines are released, the status, event and received-data registers (byte offsets 0, 1, 2) read zero, irq is low and the divider register (offset 12) reads 20.
- R2: A command (offset 4) with bit 0 set, written while idle, emits a START and then sends bits 15:9 as the 7-bit address followed by bit 2 as the read flag, most significant bit first.
- R3: At the end of every address or data byte (after the ninth SCL pulse), event bit 4 is set, irq goes high and SCL is held low with SDA released. No further SCL pulse occurs until a command with bit 7 set is written.
- R4: Status bit 3 is 1 when the target acknowledged the last address or write byte and 0 when it did not. Status bit 2 holds the read flag of the last START, bit 0 is 1 while the bus is held and bit 6 is 1 while a phase is in progress.
- R5: A command with bit 7 set and bits 2, 1, 0 clear, written while held, sends bits 15:8 as one data byte, most significant bit first.
- R6: A command with bits 7 and 1 set, written while held, produces a STOP and releases both lines, and then status bit 5 reads 1. A later START clears status bit 5.
- R7: A command with bits 7 and 2 set, written while held, receives one byte into offset 2. With bit 3 set the controller acknowledges the byte; with bit 3 clear it sends a NACK.
- R8: A command with bits 7 and 0 set, written while held, produces a repeated START (no STOP in between) and sends the new address and read flag.
- R9: If SDA reads low at the SCL-high sample point of an address or write bit that the controller sends as one, event bit 7 is set, irq goes high and both lines are released at once.
- R10: A write to the event register (offset 1) keeps only the flags whose written bit is 1, so writing zero clears all of them. irq is high exactly while any event bit is set.
- R11: A command written while a phase is in progress, or written while held without bit 7, has no effect.
- R12: The SCL period equals the divider value (a multiple of 4) in 2 MHz ticks, and each quarter of a bit lasts one quarter of that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 4 | Byte offset for register read and write |
| reg_wr | input | 1 | Write strobe for the register at reg_addr |
| reg_wdata | input | 16 | Write data; commands use all 16 bits, the other registers use bits 7:0 |
| reg_rdata | output | 16 | Read data of the register at reg_addr |
| scl_drive_low | output | 1 | Pulls SCL low when 1, releases it when 0 |
| sda_drive_low | output | 1 | Pulls SDA low when 1, releases it when 0 |
| sda_in | input | 1 | Resolved SDA level on the bus |
| irq | output | 1 | High while any event or error flag is set |

## Verification
A wrong phase or quarter counter shows up within one bit time as an SCL or SDA edge at the wrong moment. The behavioural target sees this as a corrupted address or data byte, a missing or extra START or STOP, or a changed SCL period. A lost or spurious completion event shows up at once as an irq that stays low, or as SCL pulses while the bus should be parked. A wrong acknowledge or direction flag shows up in the status byte read right after the event. Commands that should be ignored are checked through the target's bit counters and the status register before the next valid command is written.

// File: rtl/i2c_byte_engine.sv
`timescale 1ns/1ps
module i2c_byte_engine #(
  parameter int CLK_HZ = 50_000_000,
  parameter int TICK_HZ = 2_000_000,
  parameter logic [7:0] DIV_RESET = 8'd20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        scl_drive_low,
  output logic        sda_drive_low,
  input  logic        sda_in,
  output logic        irq
);
  localparam int TICK_DIV = (CLK_HZ / TICK_HZ < 1) ? 1 : CLK_HZ / TICK_HZ;
  localparam int PW = $clog2(TICK_DIV) + 1;
  localparam logic [3:0] A_STAT = 4'd0, A_EVT = 4'd1, A_RX = 4'd2, A_CMD = 4'd4, A_DIV = 4'd12;
  localparam int EV_DONE = 4, EV_ARB = 7;

  typedef enum logic [2:0] {S_IDLE, S_START, S_BIT, S_HOLD, S_STOP} st_t;
  st_t state;

  logic [1:0] q;
  logic [PW-1:0] pre;
  logic [5:0] qcnt;
  logic [7:0] sh, evt, rx, div;
  logic [3:0] bc;
  logic rd_mode, ack_en, dir, ack_st, stop_st, from_hold, samp;

  wire active = (state == S_START) || (state == S_BIT) || (state == S_STOP);
  wire [5:0] qlen = (div[7:2] == 6'd0) ? 6'd1 : div[7:2];
  wire tick = (pre == PW'(TICK_DIV - 1));
  wire qstep = active && tick && (qcnt == qlen - 6'd1);
  wire last_q = qstep && (q == 2'd3);
  wire cmd_wr = reg_wr && (reg_addr == A_CMD);
  wire clr = reg_wdata[7];
  wire take = cmd_wr && (((state == S_IDLE) && reg_wdata[0]) || ((state == S_HOLD) && clr));
  wire [7:0] status = {1'b0, active, stop_st, 1'b0, ack_st, dir, 1'b0, state == S_HOLD};

  assign irq = |evt;

  always_comb begin
    scl_drive_low = 1'b0;
    sda_drive_low = 1'b0;
    case (state)
      S_START: begin
        scl_drive_low = (q == 2'd0) ? from_hold : (q == 2'd3);
        sda_drive_low = q[1];
      end
      S_BIT: begin
        scl_drive_low = !q[1];
        sda_drive_low = bc[3] ? (rd_mode && ack_en) : (!rd_mode && !sh[7]);
      end
      S_HOLD: scl_drive_low = 1'b1;
      S_STOP: begin
        scl_drive_low = (q == 2'd0);
        sda_drive_low = !q[1];
      end
      default: ;
    endcase
  end

  always_comb begin
    case (reg_addr)
      A_STAT:  reg_rdata = {8'h00, status};
      A_EVT:   reg_rdata = {8'h00, evt};
      A_RX:    reg_rdata = {8'h00, rx};
      A_DIV:   reg_rdata = {8'h00, div};
      default: reg_rdata = 16'h0000;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      q <= 2'd0;
      pre <= '0;
      qcnt <= 6'd0;
      sh <= 8'h00;
      evt <= 8'h00;
      rx <= 8'h00;
      div <= DIV_RESET;
      bc <= 4'd0;
      rd_mode <= 1'b0;
      ack_en <= 1'b0;
      dir <= 1'b0;
      ack_st <= 1'b0;
      stop_st <= 1'b0;
      from_hold <= 1'b0;
      samp <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == A_EVT) evt <= evt & reg_wdata[7:0];
      if (reg_wr && reg_addr == A_DIV) div <= reg_wdata[7:0];
      if (cmd_wr && clr && (state == S_IDLE || state == S_HOLD)) evt[EV_DONE] <= 1'b0;

      if (active) begin
        pre <= tick ? '0 : pre + 1'b1;
        if (tick) qcnt <= (qcnt == qlen - 6'd1) ? 6'd0 : qcnt + 6'd1;
      end else begin
        pre <= '0;
        qcnt <= 6'd0;
      end
      if (qstep) q <= q + 2'd1;

      if (take) begin
        q <= 2'd0;
        bc <= 4'd0;
        if (reg_wdata[0]) begin
          state <= S_START;
          from_hold <= (state == S_HOLD);
          sh <= {reg_wdata[15:9], reg_wdata[2]};
          dir <= reg_wdata[2];
          rd_mode <= 1'b0;
          stop_st <= 1'b0;
        end else if (reg_wdata[1]) begin
          state <= S_STOP;
        end else begin
          state <= S_BIT;
          rd_mode <= reg_wdata[2];
          ack_en <= reg_wdata[3];
          sh <= reg_wdata[2] ? 8'h00 : reg_wdata[15:8];
        end
      end

      case (state)
        S_START: if (last_q) state <= S_BIT;
        S_STOP: if (last_q) begin
          state <= S_IDLE;
          stop_st <= 1'b1;
        end
        S_BIT: if (qstep) begin
          if (q == 2'd2) begin
            samp <= sda_in;
            if (bc[3]) begin
              if (!rd_mode) ack_st <= !sda_in;
            end else if (!rd_mode && sh[7] && !sda_in) begin
              evt[EV_ARB] <= 1'b1;
              state <= S_IDLE;
            end
          end else if (q == 2'd3) begin
            if (bc[3]) begin
              state <= S_HOLD;
              evt[EV_DONE] <= 1'b1;
              if (rd_mode) rx <= sh;
            end else begin
              sh <= {sh[6:0], rd_mode ? samp : 1'b1};
              bc <= bc + 4'd1;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_byte_engine_chk.sv
`timescale 1ns/1ps
module i2c_byte_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_low,
  input logic       sda_low,
  input logic       irq,
  input logic       stop_seen,
  input logic [7:0] evt
);
  assert_hold_scl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    evt[4] |-> scl_low);

  assert_hold_sda_R3: assert property (@(posedge clk) disable iff (!rst_n)
    evt[4] && $past(evt[4]) |-> $stable(sda_low));

  assert_irq_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt[4]) |-> irq);

  assert_arb_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt[7]) |-> !scl_low && !sda_low);

  assert_stop_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_seen) |-> !scl_low && !sda_low);
endmodule

bind i2c_byte_engine i2c_byte_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_low(scl_drive_low), .sda_low(sda_drive_low),
  .irq(irq), .stop_seen(stop_st), .evt(evt)
);

// File: tb/i2c_byte_engine_bench.sv
`timescale 1ns/1ps
module i2c_byte_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ = 8_000_000;
  localparam int TPQ = CLK_HZ / 2_000_000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] reg_addr = 4'd0;
  logic reg_wr = 1'b0;
  logic [15:0] reg_wdata = 16'h0000;
  logic [15:0] reg_rdata;
  logic scl_drive_low, sda_drive_low, irq;
  logic t_low = 1'b0;
  logic force_low = 1'b0;
  wire scl_bus = ~scl_drive_low;
  wire sda_bus = ~(sda_drive_low | t_low | force_low);

  int n_chk = 0, n_fail = 0, cyc = 0;

  i2c_byte_engine #(.CLK_HZ(CLK_HZ)) u_i2c_byte_engine (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_drive_low(scl_drive_low),
    .sda_drive_low(sda_drive_low), .sda_in(sda_bus), .irq(irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // behavioural target
  logic [6:0] tgt_addr = 7'h2A;
  logic tgt_nack_data = 1'b0;
  logic [7:0] tx_mem [0:3];
  logic prev_scl = 1'b1, prev_sda = 1'b1, acked = 1'b0;
  logic [7:0] sh_t = 8'h00, addr_seen = 8'h00;
  logic [7:0] rx_log [0:7];
  logic m_ack_log [0:7];
  int ph = 0, rcnt = 0, tx_idx = 0, n_start = 0, n_stop = 0, n_rise = 0, rx_n = 0, m_ack_n = 0;

  always @(posedge clk) begin
    prev_scl <= scl_bus;
    prev_sda <= sda_bus;
    if (scl_bus && prev_scl && prev_sda && !sda_bus) begin
      n_start <= n_start + 1; ph <= 1; rcnt <= 0; t_low <= 1'b0; tx_idx <= 0;
    end else if (scl_bus && prev_scl && !prev_sda && sda_bus) begin
      n_stop <= n_stop + 1; ph <= 0; t_low <= 1'b0;
    end else if (ph != 0 && scl_bus && !prev_scl) begin
      n_rise <= n_rise + 1;
      rcnt <= rcnt + 1;
      if (rcnt < 8) sh_t <= {sh_t[6:0], sda_bus};
      if (rcnt == 7) begin
        if (ph == 1) addr_seen <= {sh_t[6:0], sda_bus};
        else if (ph == 2) begin rx_log[rx_n] <= {sh_t[6:0], sda_bus}; rx_n <= rx_n + 1; end
      end
      if (rcnt == 8) begin
        if (ph == 1) ph <= !acked ? 4 : (addr_seen[0] ? 3 : 2);
        else if (ph == 3) begin
          m_ack_log[m_ack_n] <= !sda_bus;
          m_ack_n <= m_ack_n + 1;
          tx_idx <= tx_idx + 1;
          if (sda_bus) ph <= 4;
        end
      end
    end else if (ph != 0 && !scl_bus && prev_scl) begin
      if (rcnt == 9) rcnt <= 0;
      if (rcnt == 8) begin
        if (ph == 1) begin
          acked <= (addr_seen[7:1] == tgt_addr);
          t_low <= (addr_seen[7:1] == tgt_addr);
        end else if (ph == 2) t_low <= !tgt_nack_data;
        else t_low <= 1'b0;
      end else if (ph == 3) t_low <= !tx_mem[tx_idx][7 - ((rcnt == 9) ? 0 : rcnt)];
      else t_low <= 1'b0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    @(negedge clk); reg_addr = a;
    @(negedge clk); v = reg_rdata;
  endtask

  task automatic wait_irq(input string req);
    int n = 0;
    while (!irq && n < 4000) begin @(negedge clk); n++; end
    chk(req, irq, 1'b1);
  endtask

  task automatic wait_idle(input string req);
    logic [15:0] v;
    int n = 0;
    rd(4'd0, v);
    while ((v[6] || v[0]) && n < 4000) begin rd(4'd0, v); n++; end
    chk(req, {v[6], v[0]}, 2'b00);
  endtask

  task automatic scl_rise(output int t);
    logic last = scl_bus;
    forever begin
      @(negedge clk);
      if (scl_bus && !last) break;
      last = scl_bus;
    end
    t = cyc;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    chk("R1 scl released", scl_drive_low, 1'b0);
    chk("R1 sda released", sda_drive_low, 1'b0);
    chk("R1 irq", irq, 1'b0);
    rd(4'd0, v); chk("R1 status", v, 16'h0000);
    rd(4'd1, v); chk("R1 events", v, 16'h0000);
    rd(4'd2, v); chk("R1 rx", v, 16'h0000);
    rd(4'd12, v); chk("R1 divider", v, 16'd20);
  endtask

  task automatic t_write;
    logic [15:0] v;
    int r0, s0;
    wr(4'd12, 16'd4);
    wr(4'd4, {7'h2A, 9'h001});
    wait_irq("R3 irq after address");
    chk("R2 address byte", addr_seen, 8'h54);
    rd(4'd1, v); chk("R3 done event", v, 16'h0010);
    rd(4'd0, v); chk("R4 status acked write", v, 16'h0009);
    r0 = n_rise;
    repeat (200) @(negedge clk);
    chk("R3 no pulses while held", n_rise, r0);
    chk("R3 scl held low", scl_drive_low, 1'b1);
    wr(4'd4, 16'h5500);
    repeat (200) @(negedge clk);
    chk("R11 command without clear ignored", n_rise, r0);
    chk("R11 still held", irq, 1'b1);
    wr(4'd1, 16'h00FF);
    rd(4'd1, v); chk("R10 write ones keeps flags", v, 16'h0010);
    wr(4'd1, 16'h00EF);
    rd(4'd1, v); chk("R10 write zero clears", v, 16'h0000);
    chk("R10 irq low", irq, 1'b0);
    chk("R3 bus stays held", scl_drive_low, 1'b1);
    s0 = n_stop;
    wr(4'd4, 16'hA580);
    repeat (20) @(negedge clk);
    wr(4'd4, 16'h0082);
    wait_irq("R5 irq after data");
    chk("R11 stop during byte ignored", n_stop, s0);
    chk("R5 data byte", rx_log[rx_n - 1], 8'hA5);
    wr(4'd4, 16'h3C80);
    wait_irq("R5 irq after second data");
    chk("R5 second data byte", rx_log[rx_n - 1], 8'h3C);
    wr(4'd4, 16'h0082);
    wait_idle("R6 returns idle");
    chk("R6 stop seen", n_stop, s0 + 1);
    rd(4'd0, v); chk("R6 stop flag", v[5], 1'b1);
    chk("R6 lines released", {scl_drive_low, sda_drive_low}, 2'b00);
    chk("R3 irq cleared", irq, 1'b0);
  endtask

  task automatic t_nack;
    logic [15:0] v;
    wr(4'd4, {7'h33, 9'h001});
    wait_irq("R4 irq after unknown address");
    rd(4'd0, v); chk("R4 address nack", v[3], 1'b0);
    chk("R6 start clears stop flag", v[5], 1'b0);
    wr(4'd4, 16'h0082);
    wait_idle("R6 idle after nack");
    tgt_nack_data = 1'b1;
    wr(4'd4, {7'h2A, 9'h001});
    wait_irq("R4 irq address");
    rd(4'd0, v); chk("R4 address ack", v[3], 1'b1);
    wr(4'd4, 16'h7780);
    wait_irq("R4 irq data");
    rd(4'd0, v); chk("R4 data nack", v[3], 1'b0);
    tgt_nack_data = 1'b0;
    wr(4'd4, 16'h0082);
    wait_idle("R6 idle after data nack");
  endtask

  task automatic t_read;
    logic [15:0] v;
    int a0;
    tx_mem[0] = 8'h81; tx_mem[1] = 8'h7E;
    a0 = m_ack_n;
    wr(4'd4, {7'h2A, 9'h005});
    wait_irq("R2 irq read address");
    chk("R2 read address byte", addr_seen, 8'h55);
    rd(4'd0, v); chk("R4 status read dir", v, 16'h000D);
    wr(4'd4, 16'h008C);
    wait_irq("R7 irq first read");
    rd(4'd2, v); chk("R7 first byte", v, 16'h0081);
    chk("R7 master ack", m_ack_log[a0], 1'b1);
    wr(4'd4, 16'h0084);
    wait_irq("R7 irq last read");
    rd(4'd2, v); chk("R7 last byte", v, 16'h007E);
    chk("R7 master nack", m_ack_log[a0 + 1], 1'b0);
    wr(4'd4, 16'h0082);
    wait_idle("R6 idle after read");
  endtask

  task automatic t_rstart;
    logic [15:0] v;
    int s0, p0;
    tx_mem[0] = 8'hC3;
    wr(4'd4, {7'h2A, 9'h001});
    wait_irq("R8 irq address");
    wr(4'd4, 16'h1180);
    wait_irq("R8 irq data");
    s0 = n_start; p0 = n_stop;
    wr(4'd4, {7'h2A, 9'h085});
    wait_irq("R8 irq after repeated start");
    chk("R8 repeated start", n_start, s0 + 1);
    chk("R8 no stop between", n_stop, p0);
    chk("R8 new address", addr_seen, 8'h55);
    rd(4'd0, v); chk("R8 direction read", v[2], 1'b1);
    wr(4'd4, 16'h0084);
    wait_irq("R8 irq read");
    rd(4'd2, v); chk("R8 read after restart", v, 16'h00C3);
    wr(4'd4, 16'h0082);
    wait_idle("R6 idle after restart");
  endtask

  task automatic t_divider(input int dv);
    int ta, tb;
    wr(4'd12, dv[15:0]);
    wr(4'd4, {7'h2A, 9'h001});
    scl_rise(ta);
    scl_rise(ta);
    scl_rise(tb);
    chk("R12 scl period", tb - ta, dv * TPQ);
    wait_irq("R12 irq");
    wr(4'd4, 16'h0082);
    wait_idle("R12 idle");
    wr(4'd12, 16'd4);
  endtask

  task automatic t_arb;
    logic [15:0] v;
    int s0, n;
    s0 = n_start;
    wr(4'd4, {7'h7F, 9'h001});
    n = 0;
    while (n_start == s0 && n < 1000) begin @(negedge clk); n++; end
    while (scl_bus && n < 2000) begin @(negedge clk); n++; end
    force_low = 1'b1;
    wait_irq("R9 irq on arbitration loss");
    rd(4'd1, v); chk("R9 arbitration flag", v, 16'h0080);
    chk("R9 lines released", {scl_drive_low, sda_drive_low}, 2'b00);
    rd(4'd0, v); chk("R9 not busy", v[6], 1'b0);
    force_low = 1'b0;
    wr(4'd1, 16'h0000);
    rd(4'd1, v); chk("R10 all cleared", v, 16'h0000);
    chk("R10 irq low", irq, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    tx_mem[0] = 8'h00; tx_mem[1] = 8'h00; tx_mem[2] = 8'h00; tx_mem[3] = 8'h00;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset;
    t_write;
    t_nack;
    t_read;
    t_rstart;
    t_divider(4);
    t_divider(8);
    t_arb;
    repeat (20) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule